// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Random-Address Byte Read

This block is a slave on a two-wire serial bus (clock line and open-drain data line). It holds a 2048-byte storage array and answers random-address reads. The master first opens a write-direction transfer. That transfer carries the top three bits of an 11-bit memory address inside the slave address byte, followed by one word-address byte with the low eight bits. The master then issues a repeated start and sends a read-direction slave address. The slave acknowledges it and shifts out the addressed byte, most significant bit first.

Both bus lines are brought into the system clock domain through a short synchronizer chain. Start and stop conditions are detected there, and the data line is only ever pulled low, through an output enable. A preload port writes the array directly, so the array can be filled while the bus is idle. If the master acknowledges a data byte, the slave continues with the following address. If the master does not acknowledge, the slave ends the transfer and waits for a stop.

Top module: `eeprom_rr_slave`

## Requirements
- R1: After reset `sda_oe` is low and the internal address counter is 0x000, so a read-direction transfer issued before any write-direction transfer returns the byte at address 0x000.
- R2: A slave address byte whose upper four bits equal 1010 is acknowledged: `sda_oe` is high throughout the ninth clock pulse, so the data line reads low while SCL is high.
- R3: A slave address byte whose upper four bits differ from 1010 is not acknowledged. Until the next start, `sda_oe` stays low: every later bit, including ack slots and read data, reads back 1 on the bus. The address counter is left unchanged.
- R4: In a write-direction transfer, the slave address bits 3..1 (A10..A8, bit 3 most significant) and the following word-address byte (A7..A0, MSB first) load the counter with {A10..A8, A7..A0}. The word-address byte is acknowledged.
- R5: A read-direction slave address byte (bit 0 = 1) is acknowledged, and the slave then sends the byte at the counter, D7 first. Bits 3..1 of a read-direction byte do not affect the counter.
- R6: The counter increments by one after every transmitted data byte and wraps from 0x7FF to 0x000. If the master acknowledges a data byte, the next byte follows without a new address.
- R7: A data byte that the master does not acknowledge ends transmission. `sda_oe` is low after a stop, and the next transfer is served normally.
- R8: A start or stop condition anywhere in a transfer abandons it and restarts bit counting. An address byte cut short this way does not change the counter.
- R9: `sda_oe` changes only while the synchronized SCL is low. It is constant during every SCL high phase after the synchronizer delay.
- R10: A cycle with `pre_we` high writes `pre_data` into the array at `pre_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| sda_oe | output | 1 | When high, the data line is pulled low |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 11 | Preload array address |
| pre_data | input | 8 | Preload data byte |

## Verification
The array is filled with an arithmetic pattern. Random reads then sweep all eight upper-address blocks, each with word addresses 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF, while the read-direction byte always carries the inverted block bits. A wrong block choice or a swapped bit order in the counter therefore shows up as a wrong data byte. A sequential read across 0x7FE..0x000 separates a correct wrap from a carry into a wider field, and current-address reads after reset and after each step expose the counter's value. Two foreign device codes (write and read direction), a stop in the middle of a word address and a repeated start in the middle of a word address separate "ignored" from "half-applied" behaviour. A bus monitor watches for data-line changes during SCL high phases.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_DEV,
      ST_ACK_DEV,
      ST_RX_WORD,
      ST_ACK_WORD,
      ST_TX,
      ST_MACK,
      ST_IGNORE
   } rr_state_e;

endpackage

// File: rtl/rr_line_sync.sv
module rr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_prev;
   logic              sda_prev;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_ff[STAGES-1];
   assign sda_s = sda_ff[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/rr_store.sv
module rr_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
   import rr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CODE_W = 4,
   parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010,
   localparam int BLK_W  = DATA_W - 1 - CODE_W,
   localparam int ADDR_W = DATA_W + BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr_cnt,
   output logic              sda_oe,
   output rr_state_e         state
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [BLK_W-1:0]  blk_hold;
   logic              rnw;
   logic              mack_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         blk_hold <= '0;
         rnw      <= 1'b0;
         mack_ok  <= 1'b0;
         addr_cnt <= '0;
         sda_oe   <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_RX_DEV;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_RX_DEV: begin
               if (scl_rise && cnt < CNT_FULL) begin
                  sh  <= {sh[DATA_W-2:0], sda_s};
                  cnt <= cnt + CNT_ONE;
               end else if (scl_fall && cnt == CNT_FULL) begin
                  cnt <= '0;
                  if (sh[DATA_W-1 -: CODE_W] == DEV_CODE) begin
                     rnw      <= sh[0];
                     blk_hold <= sh[BLK_W:1];
                     sda_oe   <= 1'b1;
                     state    <= ST_ACK_DEV;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            ST_ACK_DEV: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (rnw) begin
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX_WORD;
                  end
               end
            end
            ST_RX_WORD: begin
               if (scl_rise && cnt < CNT_FULL) begin
                  sh  <= {sh[DATA_W-2:0], sda_s};
                  cnt <= cnt + CNT_ONE;
               end else if (scl_fall && cnt == CNT_FULL) begin
                  cnt      <= '0;
                  addr_cnt <= {blk_hold, sh};
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK_WORD;
               end
            end
            ST_ACK_WORD: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_IGNORE;
               end
            end
            ST_TX: begin
               if (scl_rise && cnt < CNT_FULL) begin
                  cnt <= cnt + CNT_ONE;
               end else if (scl_fall) begin
                  if (cnt == CNT_FULL) begin
                     sda_oe   <= 1'b0;
                     addr_cnt <= addr_cnt + ADDR_W'(1);
                     cnt      <= '0;
                     state    <= ST_MACK;
                  end else begin
                     sh     <= {sh[DATA_W-2:0], 1'b0};
                     sda_oe <= ~sh[DATA_W-2];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  mack_ok <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack_ok) begin
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     cnt    <= '0;
                     state  <= ST_TX;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/eeprom_rr_slave.sv
module eeprom_rr_slave
   import rr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CODE_W      = 4,
   parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010,
   parameter int SYNC_STAGES = 2,
   localparam int BLK_W  = DATA_W - 1 - CODE_W,
   localparam int ADDR_W = DATA_W + BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              pre_we,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [DATA_W-1:0] pre_data
);

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("eeprom_rr_slave: DATA_W must be at least 4");
      end
      if (CODE_W < 1 || BLK_W < 1) begin : g_bad_split
         $error("eeprom_rr_slave: slave byte needs a code field and a block field");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("eeprom_rr_slave: SYNC_STAGES must be 1 to 4");
      end
      if (ADDR_W > 14) begin : g_bad_depth
         $error("eeprom_rr_slave: array too deep");
      end
   endgenerate

   logic              scl_q;
   logic              sda_q;
   logic              rise_q;
   logic              fall_q;
   logic              start_q;
   logic              stop_q;
   logic [ADDR_W-1:0] addr_cnt;
   logic [DATA_W-1:0] rd_data;
   rr_state_e         ctrl_state;

   rr_line_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_q),
      .sda_s     (sda_q),
      .scl_rise  (rise_q),
      .scl_fall  (fall_q),
      .start_det (start_q),
      .stop_det  (stop_q)
   );

   rr_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_store (
      .clk   (clk),
      .we    (pre_we),
      .waddr (pre_addr),
      .wdata (pre_data),
      .raddr (addr_cnt),
      .rdata (rd_data)
   );

   rr_ctrl #(
      .DATA_W   (DATA_W),
      .CODE_W   (CODE_W),
      .DEV_CODE (DEV_CODE)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (rise_q),
      .scl_fall  (fall_q),
      .start_det (start_q),
      .stop_det  (stop_q),
      .sda_s     (sda_q),
      .rd_data   (rd_data),
      .addr_cnt  (addr_cnt),
      .sda_oe    (sda_oe),
      .state     (ctrl_state)
   );

endmodule

// File: rtl/rr_checker.sv
module rr_checker
   import rr_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      scl_s,
   input logic      start_det,
   input logic      stop_det,
   input logic      sda_oe,
   input rr_state_e st
);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !sda_oe);

   assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK_DEV || st == ST_ACK_WORD) |-> sda_oe);

   assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !sda_oe);

   assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

endmodule

bind eeprom_rr_slave rr_checker i_rr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_q),
   .start_det (start_q),
   .stop_det  (stop_q),
   .sda_oe    (sda_oe),
   .st        (ctrl_state)
);

// File: tb/test_eeprom_rr_slave.sv
`timescale 1ns/1ps
module test_eeprom_rr_slave;

   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_oe;
   logic        sda_line;
   logic        pre_we = 1'b0;
   logic [10:0] pre_addr = '0;
   logic [7:0]  pre_data = '0;

   int n_chk = 0;
   int n_fail = 0;
   int hi_cnt = 0;
   int glitches = 0;
   logic prev_oe = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   eeprom_rr_slave i_eeprom_rr_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .pre_we   (pre_we),
      .pre_addr (pre_addr),
      .pre_data (pre_data)
   );

   // R9 monitor: no change of the pull-down while SCL is settled high
   always @(negedge clk) begin
      if (m_scl) hi_cnt = hi_cnt + 1;
      else hi_cnt = 0;
      if (rst_n && hi_cnt > 4 && sda_oe != prev_oe) glitches = glitches + 1;
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] pat(int a);
      return 8'((a * 7) ^ (a >> 3) ^ 'h5A);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic bit_out(logic b);
      m_sda = b;    wq(Q);
      m_scl = 1'b1; wq(2 * Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      b = sda_line; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic send_byte(logic [7:0] v, output int ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(a);
      ack = a ? 0 : 1;
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      bit_out(mack ? 1'b0 : 1'b1);
   endtask

   task automatic rand_read(int blk, int word, int rdblk, output logic [7:0] d,
                            output int a1, output int a2, output int a3);
      bus_start();
      send_byte({4'hA, 3'(blk), 1'b0}, a1);
      send_byte(8'(word), a2);
      bus_start();
      send_byte({4'hA, 3'(rdblk), 1'b1}, a3);
      recv_byte(d, 1'b0);
      bus_stop();
   endtask

   task automatic cur_read(output logic [7:0] d, output int a);
      bus_start();
      send_byte(8'hA1, a);
      recv_byte(d, 1'b0);
      bus_stop();
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [7:0] d, d1, d2;
      int a1, a2, a3;
      int wl[6] = '{0, 1, 127, 128, 254, 255};

      wq(10);
      chk("R1 sda_oe in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      wq(5);
      chk("R1 sda_oe after reset", int'(sda_oe), 0);

      // R10 preload whole array
      for (int a = 0; a < 2048; a++) begin
         pre_we = 1'b1; pre_addr = 11'(a); pre_data = pat(a);
         wq(1);
      end
      pre_we = 1'b0;
      wq(Q);

      // R1 counter starts at zero
      cur_read(d, a1);
      chk("R2 read-direction address ack", a1, 1);
      chk("R1 first current read at 0x000", int'(d), int'(pat(0)));

      // R4 R5 R10 sweep over blocks and boundary words
      for (int blk = 0; blk < 8; blk++) begin
         for (int k = 0; k < 6; k++) begin
            rand_read(blk, wl[k], 7 - blk, d, a1, a2, a3);
            chk("R2 write-direction address ack", a1, 1);
            chk("R4 word address ack", a2, 1);
            chk("R5 read address ack", a3, 1);
            chk("R5 R10 random read data", int'(d), int'(pat(blk * 256 + wl[k])));
         end
      end

      // R6 sequential read with wrap
      bus_start();
      send_byte(8'hAE, a1);
      send_byte(8'hFE, a2);
      bus_start();
      send_byte(8'hA1, a3);
      chk("R6 setup acks", a1 + a2 + a3, 3);
      recv_byte(d, 1'b1);
      recv_byte(d1, 1'b1);
      recv_byte(d2, 1'b0);
      bus_stop();
      chk("R6 byte at 0x7FE", int'(d), int'(pat(2046)));
      chk("R6 byte at 0x7FF", int'(d1), int'(pat(2047)));
      chk("R6 wrap to 0x000", int'(d2), int'(pat(0)));
      cur_read(d, a1);
      chk("R7 transfer after nack-stop acked", a1, 1);
      chk("R6 counter now 0x001", int'(d), int'(pat(1)));
      chk("R7 released after stop", int'(sda_oe), 0);

      // R3 foreign device code, write direction
      rand_read(1, 'h23, 1, d, a1, a2, a3);
      chk("R4 setup read 0x123", int'(d), int'(pat('h123)));
      bus_start();
      send_byte(8'h6A, a1);
      chk("R3 foreign code not acked", a1, 0);
      send_byte(8'h55, a2);
      chk("R3 following byte not acked", a2, 0);
      bus_stop();
      cur_read(d, a1);
      chk("R3 counter unchanged 0x124", int'(d), int'(pat('h124)));

      // R3 foreign device code, read direction
      bus_start();
      send_byte(8'hB1, a1);
      chk("R3 foreign read code not acked", a1, 0);
      recv_byte(d, 1'b0);
      chk("R3 no data driven", int'(d), 'hFF);
      bus_stop();

      // R8 stop mid word address
      bus_start();
      send_byte(8'hA4, a1);
      chk("R8 address ack before abort", a1, 1);
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      bus_stop();
      cur_read(d, a1);
      chk("R8 counter kept after stop abort", int'(d), int'(pat('h125)));

      // R8 repeated start mid word address
      bus_start();
      send_byte(8'hA6, a1);
      for (int i = 0; i < 3; i++) bit_out(1'b1);
      bus_start();
      send_byte(8'hA1, a2);
      chk("R8 read after restart acked", a2, 1);
      recv_byte(d, 1'b0);
      bus_stop();
      chk("R8 counter kept after restart abort", int'(d), int'(pat('h126)));

      chk("R9 no data-line change while SCL high", glitches, 0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule